// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block produces the internal reset for the whole chip from three inputs: a digitized supply-good flag from a power-on comparator, an active-low external reset pin, and a flag that says whether the low-voltage monitor is switched on. While the supply flag is low, the chip is held in reset. When the supply comes up, the block first waits a supply-stabilization time. It then releases the chip only after a processing delay, counted in ticks of a reference clock enable.

The processing delay is one of four parameters. Which one is used depends on two things: whether a release has already completed since the supply last came up, and whether the low-voltage monitor is on. During the processing delay the on-chip oscillator enable is already high, but the CPU run flag stays low. A status output reports which delay was chosen.

The pin passes through a two-flop synchronizer. A low level on the pin counts as an external reset only once it has lasted a minimum number of ticks. When the monitor is off, the pin must be high before the power-on release can go ahead. A new reset cause that arrives while a wait is running aborts that wait.

Top module: `por_release_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `core_rst`=1, `osc_en`=0, `cpu_run`=0 and `rel_sel`=2'b00.
- R2: One cycle after `supply_ok` is sampled low, `core_rst`=1, `osc_en`=0 and `cpu_run`=0. This holds whatever state the block was in, and a low supply flag also clears the memory of a completed release.
- R3: After `supply_ok` rises with the pin high, `osc_en` stays low for exactly STAB_TICKS ticks plus one cycle before the processing phase begins.
- R4: A synchronized low on `ext_rst_n` is a reset only after it has lasted PIN_MIN_TICKS ticks. If it does so during processing or normal operation, the block returns to the held state. A shorter low has no effect on `cpu_run` or `core_rst`.
- R5: With `lvd_en`=0, the power-on release does not leave the held state while the synchronized pin is low, however long the stabilization has run.
- R6: The processing phase shows `core_rst`=1, `osc_en`=1 and `cpu_run`=0. With a tick on every cycle, it lasts exactly the chosen delay in cycles.
- R7: `rel_sel` = {later, lvd_en} is latched at the start of processing and held: 2'b00 selects FIRST_OFF_TICKS, 2'b01 FIRST_ON_TICKS, 2'b10 LATER_OFF_TICKS, 2'b11 LATER_ON_TICKS.
- R8: "later" is 0 until a processing phase completes after the supply rises. It stays 1 for every following release until `supply_ok` drops.
- R9: A processing phase aborted by a valid pin reset does not count as completed, so the next release still uses the first-release delays.
- R10: In normal operation `core_rst`=0, `osc_en`=1 and `cpu_run`=1, and `core_rst` only falls directly from the processing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| tick | input | 1 | Reference tick enable, one pulse per time unit |
| supply_ok | input | 1 | Digitized power-on comparator flag, 1 = supply above threshold |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lvd_en | input | 1 | Low-voltage monitor enabled |
| core_rst | output | 1 | Registered internal reset, active high |
| osc_en | output | 1 | On-chip oscillator enable |
| cpu_run | output | 1 | CPU allowed to execute |
| rel_sel | output | 2 | Delay chosen for the latest processing phase |

## Verification
Release sequences are driven as power cycles and as pin pulses, each with the monitor on and off. This separates all four delay codes and shows whether the first-versus-later memory is set, kept and cleared at the right moments. A pin glitch shorter than the filter tells a filtered pin apart from a raw one. A held-low pin with the monitor off shows that the power-on release waits for the pin. Aborts during processing, by the pin and by the supply, show that only a completed phase marks a release as done.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_STAB = 3'd1,
    ST_HOLD = 3'd2,
    ST_PROC = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  // Delay select code: bit 1 = a release already completed, bit 0 = monitor on
  typedef logic [1:0] rel_code_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max_of6(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d,
                                          input int unsigned e, input int unsigned f);
    return max2(max2(max2(a, b), max2(c, d)), max2(e, f));
  endfunction

endpackage

// File: rtl/por_pin_filter.sv
module por_pin_filter #(
  parameter int unsigned MIN_TICKS = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_n,
  output logic pin_high,
  output logic pin_hold
);
  localparam int unsigned FW = $clog2(MIN_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FW-1:0]          low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign pin_high = sync_q[SYNC_STAGES-1];

  // Count ticks of a continuous synchronized low, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || pin_high)
      low_cnt_q <= '0;
    else if (tick && (low_cnt_q != FW'(MIN_TICKS)))
      low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign pin_hold = (low_cnt_q == FW'(MIN_TICKS));

endmodule

// File: rtl/por_tick_timer.sv
module por_tick_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  // Fires on the tick that completes 'limit' ticks since start
  assign done = tick && (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_pkg::*;
#(
  parameter int unsigned CW              = 10,
  parameter int unsigned STAB_TICKS      = 990,
  parameter int unsigned FIRST_ON_TICKS  = 672,
  parameter int unsigned FIRST_OFF_TICKS = 399,
  parameter int unsigned LATER_ON_TICKS  = 531,
  parameter int unsigned LATER_OFF_TICKS = 259
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          lvd_en,
  input  logic          pin_high,
  input  logic          pin_hold,
  input  logic          timer_done,
  output logic          timer_start,
  output logic [CW-1:0] timer_limit,
  output logic          core_rst,
  output logic          osc_en,
  output logic          cpu_run,
  output rel_code_t     rel_sel
);
  seq_state_t    state_q, state_d;
  logic          later_q;
  logic [CW-1:0] proc_len_q;
  rel_code_t     sel_q;
  rel_code_t     sel_d;
  logic          hold_exit;

  logic [CW-1:0] delay_tab [4];
  assign delay_tab[0] = CW'(FIRST_OFF_TICKS);
  assign delay_tab[1] = CW'(FIRST_ON_TICKS);
  assign delay_tab[2] = CW'(LATER_OFF_TICKS);
  assign delay_tab[3] = CW'(LATER_ON_TICKS);

  assign sel_d = {later_q, lvd_en};

  // Monitor off: the pin itself must be released; monitor on: only a valid pin reset blocks
  assign hold_exit = lvd_en ? !pin_hold : pin_high;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_STAB;
        ST_STAB: if (timer_done) state_d = ST_HOLD;
        ST_HOLD: if (hold_exit) state_d = ST_PROC;
        ST_PROC: begin
          if (pin_hold)        state_d = ST_HOLD;
          else if (timer_done) state_d = ST_RUN;
        end
        ST_RUN:  if (pin_hold) state_d = ST_HOLD;
        default: state_d = ST_OFF;
      endcase
    end
  end

  assign timer_start = (state_d != state_q);
  assign timer_limit = (state_q == ST_STAB) ? CW'(STAB_TICKS) : proc_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      later_q    <= 1'b0;
      proc_len_q <= CW'(FIRST_OFF_TICKS);
      sel_q      <= 2'b00;
      core_rst   <= 1'b1;
      osc_en     <= 1'b0;
      cpu_run    <= 1'b0;
    end else begin
      state_q  <= state_d;
      core_rst <= (state_d != ST_RUN);
      osc_en   <= (state_d == ST_PROC) || (state_d == ST_RUN);
      cpu_run  <= (state_d == ST_RUN);
      if (!supply_ok)
        later_q <= 1'b0;
      else if (state_q == ST_PROC && state_d == ST_RUN)
        later_q <= 1'b1;
      if (state_q == ST_HOLD && state_d == ST_PROC) begin
        proc_len_q <= delay_tab[sel_d];
        sel_q      <= sel_d;
      end
    end
  end

  assign rel_sel = sel_q;

endmodule

// File: rtl/por_release_seq.sv
module por_release_seq
  import por_pkg::*;
#(
  parameter int unsigned STAB_TICKS      = 990,
  parameter int unsigned FIRST_ON_TICKS  = 672,
  parameter int unsigned FIRST_OFF_TICKS = 399,
  parameter int unsigned LATER_ON_TICKS  = 531,
  parameter int unsigned LATER_OFF_TICKS = 259,
  parameter int unsigned PIN_MIN_TICKS   = 10,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       ext_rst_n,
  input  logic       lvd_en,
  output logic       core_rst,
  output logic       osc_en,
  output logic       cpu_run,
  output logic [1:0] rel_sel
);
  localparam int unsigned MAX_T = max_of6(STAB_TICKS, FIRST_ON_TICKS, FIRST_OFF_TICKS,
                                          LATER_ON_TICKS, LATER_OFF_TICKS, 1);
  localparam int unsigned CW = $clog2(MAX_T + 1);

  logic          pin_high, pin_hold;
  logic          t_start, t_done;
  logic [CW-1:0] t_limit;

  por_pin_filter #(
    .MIN_TICKS  (PIN_MIN_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pin (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pin_n   (ext_rst_n),
    .pin_high(pin_high),
    .pin_hold(pin_hold)
  );

  por_tick_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .start(t_start),
    .limit(t_limit),
    .done (t_done)
  );

  por_seq_fsm #(
    .CW             (CW),
    .STAB_TICKS     (STAB_TICKS),
    .FIRST_ON_TICKS (FIRST_ON_TICKS),
    .FIRST_OFF_TICKS(FIRST_OFF_TICKS),
    .LATER_ON_TICKS (LATER_ON_TICKS),
    .LATER_OFF_TICKS(LATER_OFF_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .lvd_en     (lvd_en),
    .pin_high   (pin_high),
    .pin_hold   (pin_hold),
    .timer_done (t_done),
    .timer_start(t_start),
    .timer_limit(t_limit),
    .core_rst   (core_rst),
    .osc_en     (osc_en),
    .cpu_run    (cpu_run),
    .rel_sel    (rel_sel)
  );

endmodule

// File: rtl/por_release_seq_chk.sv
module por_release_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       core_rst,
  input logic       osc_en,
  input logic       cpu_run,
  input logic [1:0] rel_sel
);
  assert_supply_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (core_rst && !osc_en && !cpu_run));

  assert_cpu_gated_R6: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> !cpu_run);

  assert_osc_rise_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> core_rst);

  assert_sel_held_R7: assert property (@(posedge clk) disable iff (rst)
    (osc_en && core_rst && $past(osc_en && core_rst)) |-> $stable(rel_sel));

  assert_run_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> (osc_en && cpu_run));

  assert_release_from_proc_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(osc_en));
endmodule

bind por_release_seq por_release_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .supply_ok(supply_ok),
  .core_rst (core_rst),
  .osc_en   (osc_en),
  .cpu_run  (cpu_run),
  .rel_sel  (rel_sel)
);

// File: tb/tb_por_release_seq.sv
module tb_por_release_seq;
  localparam int STAB = 40;
  localparam int F_ON = 30;
  localparam int F_OFF = 20;
  localparam int L_ON = 25;
  localparam int L_OFF = 12;
  localparam int PMIN = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_ok = 1'b0;
  logic ext_rst_n = 1'b1;
  logic lvd_en = 1'b0;
  logic core_rst, osc_en, cpu_run;
  logic [1:0] rel_sel;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  por_release_seq #(
    .STAB_TICKS(STAB), .FIRST_ON_TICKS(F_ON), .FIRST_OFF_TICKS(F_OFF),
    .LATER_ON_TICKS(L_ON), .LATER_OFF_TICKS(L_OFF), .PIN_MIN_TICKS(PMIN),
    .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n),
    .lvd_en(lvd_en), .core_rst(core_rst), .osc_en(osc_en), .cpu_run(cpu_run),
    .rel_sel(rel_sel)
  );

  // Vector: {action (0 = power cycle, 1 = pin pulse), lvd_en, expected rel_sel}
  localparam logic [3:0] VEC [0:6] = '{
    4'b0_0_00, 4'b1_0_10, 4'b1_1_11, 4'b0_1_01, 4'b1_1_11, 4'b1_0_10, 4'b0_0_00
  };

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'b00: return F_OFF;
      2'b01: return F_ON;
      2'b10: return L_OFF;
      default: return L_ON;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Supply low then high; returns cycles with osc_en low after the rise
  task automatic power_cycle(input logic lvd, output int stab_cnt);
    @(negedge clk);
    supply_ok = 1'b0;
    lvd_en = lvd;
    cycles(3);
    check(core_rst && !osc_en && !cpu_run, "R2 supply low forces reset",
          {core_rst, osc_en, cpu_run}, 3'b100);
    supply_ok = 1'b1;
    stab_cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (osc_en) break;
      stab_cnt++;
    end
  endtask

  task automatic pin_pulse(input logic lvd, input int n);
    @(negedge clk);
    lvd_en = lvd;
    ext_rst_n = 1'b0;
    cycles(n);
    ext_rst_n = 1'b1;
  endtask

  // Waits for the processing phase and measures its length
  task automatic measure(output int len, output logic [1:0] sel);
    len = 0;
    sel = 2'b00;
    for (int i = 0; i < 5000; i++) begin
      if (osc_en && core_rst) break;
      @(negedge clk);
    end
    while (osc_en && core_rst && len < 5000) begin
      check(!cpu_run, "R6 cpu held during processing", cpu_run, 0);
      sel = rel_sel;
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int sc, ln;
    logic [1:0] sl;
    cycles(3);
    check(core_rst && !osc_en && !cpu_run && rel_sel == 2'b00, "R1 reset state",
          {core_rst, osc_en, cpu_run, rel_sel}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    check(core_rst && !osc_en && !cpu_run && rel_sel == 2'b00, "R1 first cycle after reset",
          {core_rst, osc_en, cpu_run, rel_sel}, 5'b10000);

    // Table walk
    for (int v = 0; v < 7; v++) begin
      if (VEC[v][3] == 1'b0) begin
        power_cycle(VEC[v][2], sc);
        check(sc == STAB + 1, "R3 stabilization length", sc, STAB + 1);
      end else begin
        pin_pulse(VEC[v][2], PMIN + 8);
        check(core_rst && !cpu_run, "R4 valid pin reset", core_rst, 1);
      end
      measure(ln, sl);
      check(sl == VEC[v][1:0], "R7 R8 delay select", sl, VEC[v][1:0]);
      check(ln == len_of(VEC[v][1:0]), "R6 processing length", ln, len_of(VEC[v][1:0]));
      cycles(2);
      check(!core_rst && osc_en && cpu_run, "R10 run outputs",
            {core_rst, osc_en, cpu_run}, 3'b011);
    end

    // Short pin glitch is ignored
    pin_pulse(1'b0, PMIN - 5);
    for (int i = 0; i < PMIN + 6; i++) begin
      @(negedge clk);
      if (core_rst || !cpu_run) begin
        check(0, "R4 short glitch ignored", core_rst, 0);
        break;
      end
    end
    check(!core_rst && cpu_run, "R4 short glitch still running", cpu_run, 1);

    // Monitor off: pin low holds the power-on release
    @(negedge clk);
    ext_rst_n = 1'b0;
    power_cycle(1'b0, sc);
    check(sc >= 4000 && core_rst && !osc_en, "R5 pin low blocks release", sc, 5000);
    ext_rst_n = 1'b1;
    measure(ln, sl);
    check(sl == 2'b00 && ln == F_OFF, "R5 release after pin high", {sl, 8'(ln)}, {2'b00, 8'(F_OFF)});
    cycles(2);

    // Pin abort during a first release keeps the first-release delays
    power_cycle(1'b1, sc);
    cycles(5);
    ext_rst_n = 1'b0;
    cycles(PMIN + 6);
    check(core_rst && !osc_en, "R9 pin abort returns to hold", {core_rst, osc_en}, 2'b10);
    ext_rst_n = 1'b1;
    measure(ln, sl);
    check(sl == 2'b01 && ln == F_ON, "R9 abort not counted as release",
          {sl, 8'(ln)}, {2'b01, 8'(F_ON)});
    cycles(2);

    // Supply abort during a later release clears the release memory
    pin_pulse(1'b1, PMIN + 8);
    for (int i = 0; i < 100; i++) begin
      if (osc_en && core_rst) break;
      @(negedge clk);
    end
    cycles(3);
    supply_ok = 1'b0;
    @(negedge clk);
    check(core_rst && !osc_en, "R2 supply abort during processing", {core_rst, osc_en}, 2'b10);
    supply_ok = 1'b1;
    measure(ln, sl);
    check(sl == 2'b01 && ln == F_ON, "R2 R8 memory cleared by supply drop",
          {sl, 8'(ln)}, {2'b01, 8'(F_ON)});

    // Sparse ticks: length counted in ticks, not cycles
    cycles(2);
    pin_pulse(1'b0, 2 * (PMIN + 8));
    for (int i = 0; i < 100; i++) begin
      if (osc_en && core_rst) break;
      @(negedge clk);
    end
    tick = 1'b0;
    cycles(6);
    check(core_rst && osc_en, "R6 no progress without ticks", {core_rst, osc_en}, 2'b11);
    tick = 1'b1;
    measure(ln, sl);
    check(ln == L_OFF, "R6 tick-counted length", ln, L_OFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule